// File: doc/BRIEF.md
# Drain Fault Monitor with Short-Circuit Retry

One instance of this block watches one low-side output channel. It receives the channel's gate request and a comparator bit, already synchronized to the clock, that reads high when the drain sits above the fault threshold. With the gate conducting, a drain that stays high means a load short. With the gate off, a drain that stays low means an open load or a short to ground. Both conditions set the same live fault flag, and each must persist for its own qualification time, counted in clock cycles, before the flag rises.

A confirmed short does not latch the channel off. The monitor raises a chop signal that holds the gate low for a long refresh interval. It then releases the gate for one sense window. If the drain rises again in that window, the short is re-qualified and the cycle repeats, which gives a very low duty cycle into the short. The loop ends when the request drops or when a retry window passes with the drain held low. The fault flag stays high through refresh and retry and clears only after that clean window.

Top module: `drain_fault_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fault` and `chop` are 0 and `gate_drive` equals `gate_req`, which is 0 during reset in normal use.
- R2: When `chop` is 0, `gate_drive` equals `gate_req`. When `chop` is 1, `gate_drive` is 0.
- R3: A short is confirmed when `drain_high` is sampled 1 on `SENSE_CYC` consecutive rising edges while the gate is driven. On the cycle after the last of those edges, `chop` and `fault` are both 1.
- R4: Once started by a short, `chop` stays 1 for exactly `REFRESH_CYC` cycles while the request stays high. The gate is then driven again.
- R5: `fault` stays 1 through refresh and through the following retry window. It returns to 0 one cycle after `drain_high` has been sampled 0 on `SENSE_CYC` consecutive edges of a retry window with the gate driven.
- R6: If the drain is still high in the retry window, the short is qualified again and another refresh interval follows. The result is `SENSE_CYC` driven cycles to each `REFRESH_CYC` chopped cycles.
- R7: If `gate_req` is sampled 0 during refresh, `chop` is 0 on the next cycle and the retry sequence is abandoned.
- R8: With `gate_req` 0, an open load is flagged when `drain_high` is sampled 0 on `OPEN_CYC` consecutive edges. While the gate is driven and no retry is pending, `fault` is 0.
- R9: With `gate_req` 0 and `drain_high` sampled 1, `fault` is 0 on the next cycle.
- R10: Any change of the comparator level or of the gate state restarts qualification. A run one edge shorter than the limit never raises `fault`.
- R11: `drain_high` has no effect during refresh. Neither `chop` timing nor `fault` changes with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_req | input | 1 | Channel on-request |
| drain_high | input | 1 | Synchronized comparator: drain above fault threshold |
| gate_drive | output | 1 | Gate enable to the output driver |
| chop | output | 1 | High while the gate is forced off for refresh |
| fault | output | 1 | Live channel fault flag (short or open load) |

## Verification
The hardest state to reach from the ports is the retry window that follows a refresh. The fault flag there depends on memory of an earlier short, not on the present inputs. The stimulus holds the drain high across several full refresh periods so the loop repeats. It then drives the drain low across a refresh boundary so a window completes cleanly and the flag clears. It also drops the request partway through a refresh, once with the drain high and once with it low, so that both exits from the loop are exercised.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE_OFF  = 3'd0,
      ST_OFF_SENSE = 3'd1,
      ST_ON_RUN    = 3'd2,
      ST_ON_SENSE  = 3'd3,
      ST_REFRESH   = 3'd4
   } mon_state_t;

   typedef enum logic [1:0] {
      CNT_CLEAR = 2'd0,
      CNT_LOAD1 = 2'd1,
      CNT_STEP  = 2'd2
   } cnt_op_t;

endpackage

// File: rtl/dfm_qual_counter.sv
module dfm_qual_counter
   import dfm_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cnt_op_t          op,
   output logic [WIDTH-1:0] cnt_q
);

   localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (op)
            CNT_CLEAR: cnt_q <= '0;
            CNT_LOAD1: cnt_q <= CNT_ONE;
            CNT_STEP:  if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
            default:   cnt_q <= '0;
         endcase
      end
   end

endmodule

// File: rtl/dfm_ctrl.sv
module dfm_ctrl
   import dfm_pkg::*;
#(
   parameter int SENSE_CYC   = 2800,
   parameter int OPEN_CYC    = 2800,
   parameter int REFRESH_CYC = 1640000,
   parameter int CW          = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          gate_req,
   input  logic          drain_high,
   input  logic [CW-1:0] cnt_q,
   output cnt_op_t       cnt_op,
   output logic          chop,
   output logic          fault
);

   localparam logic [CW-1:0] SENSE_LAST = CW'(SENSE_CYC - 1);
   localparam logic [CW-1:0] OPEN_LAST  = CW'(OPEN_CYC - 1);
   localparam logic [CW-1:0] REFR_LAST  = CW'(REFRESH_CYC - 1);

   mon_state_t st_q, st_d;
   logic       flt_q, flt_d;
   logic       rty_q, rty_d;

   logic cont_off, cont_on_lo, cont_on_hi;
   logic hit_open, hit_short, hit_window, hit_refr;

   // a run that continues counts on from cnt_q; a new run holds one sample
   assign cont_off   = (st_q == ST_OFF_SENSE);
   assign cont_on_lo = (st_q == ST_ON_RUN);
   assign cont_on_hi = (st_q == ST_ON_SENSE);

   assign hit_open   = cont_off   ? (cnt_q >= OPEN_LAST)  : (OPEN_CYC == 1);
   assign hit_short  = cont_on_hi ? (cnt_q >= SENSE_LAST) : (SENSE_CYC == 1);
   assign hit_window = cont_on_lo ? (cnt_q >= SENSE_LAST) : (SENSE_CYC == 1);
   assign hit_refr   = (cnt_q >= REFR_LAST);

   always_comb begin
      st_d   = st_q;
      flt_d  = flt_q;
      rty_d  = rty_q;
      cnt_op = CNT_CLEAR;
      if (!gate_req) begin
         rty_d = 1'b0;
         if (drain_high) begin
            st_d   = ST_IDLE_OFF;
            flt_d  = 1'b0;
            cnt_op = CNT_CLEAR;
         end else begin
            st_d   = ST_OFF_SENSE;
            flt_d  = hit_open | (cont_off & flt_q);
            cnt_op = cont_off ? CNT_STEP : CNT_LOAD1;
         end
      end else if (st_q == ST_REFRESH) begin
         cnt_op = CNT_STEP;
         if (hit_refr) begin
            st_d   = ST_ON_RUN;
            cnt_op = CNT_CLEAR;
         end
      end else if (drain_high) begin
         if (hit_short) begin
            st_d   = ST_REFRESH;
            flt_d  = 1'b1;
            rty_d  = 1'b1;
            cnt_op = CNT_CLEAR;
         end else begin
            st_d   = ST_ON_SENSE;
            flt_d  = rty_q ? flt_q : 1'b0;
            cnt_op = cont_on_hi ? CNT_STEP : CNT_LOAD1;
         end
      end else begin
         st_d   = ST_ON_RUN;
         cnt_op = cont_on_lo ? CNT_STEP : CNT_LOAD1;
         if (!rty_q) begin
            flt_d = 1'b0;
         end else if (hit_window) begin
            flt_d = 1'b0;
            rty_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE_OFF;
         flt_q <= 1'b0;
         rty_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         flt_q <= flt_d;
         rty_q <= rty_d;
      end
   end

   assign chop  = (st_q == ST_REFRESH);
   assign fault = flt_q;

endmodule

// File: rtl/drain_fault_monitor.sv
module drain_fault_monitor
   import dfm_pkg::*;
#(
   parameter int SENSE_CYC   = 2800,
   parameter int OPEN_CYC    = 2800,
   parameter int REFRESH_CYC = 1640000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_req,
   input  logic drain_high,
   output logic gate_drive,
   output logic chop,
   output logic fault
);

   localparam int MAX_AB = (SENSE_CYC > OPEN_CYC) ? SENSE_CYC : OPEN_CYC;
   localparam int MAX_C  = (MAX_AB > REFRESH_CYC) ? MAX_AB : REFRESH_CYC;
   localparam int CW     = (MAX_C < 2) ? 1 : $clog2(MAX_C + 1);

   initial begin
      if (SENSE_CYC < 1)   $fatal(1, "SENSE_CYC must be at least 1");
      if (OPEN_CYC < 1)    $fatal(1, "OPEN_CYC must be at least 1");
      if (REFRESH_CYC < 1) $fatal(1, "REFRESH_CYC must be at least 1");
   end

   cnt_op_t       cnt_op;
   logic [CW-1:0] cnt_q;
   logic          chop_i;

   dfm_qual_counter #(
      .WIDTH (CW)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (cnt_op),
      .cnt_q (cnt_q)
   );

   dfm_ctrl #(
      .SENSE_CYC   (SENSE_CYC),
      .OPEN_CYC    (OPEN_CYC),
      .REFRESH_CYC (REFRESH_CYC),
      .CW          (CW)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_req   (gate_req),
      .drain_high (drain_high),
      .cnt_q      (cnt_q),
      .cnt_op     (cnt_op),
      .chop       (chop_i),
      .fault      (fault)
   );

   assign chop       = chop_i;
   assign gate_drive = gate_req & ~chop_i;

endmodule

// File: rtl/dfm_checker.sv
module dfm_checker #(
   parameter int REFRESH_CYC = 1640000
) (
   input logic clk,
   input logic rst_n,
   input logic gate_req,
   input logic drain_high,
   input logic gate_drive,
   input logic chop,
   input logic fault
);

   int chop_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    chop_len <= 0;
      else if (chop) chop_len <= chop_len + 1;
      else           chop_len <= 0;
   end

   p_chop_blocks_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      chop |-> !gate_drive);

   p_chop_needs_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chop) |-> ($past(gate_req) && $past(drain_high) && fault));

   p_chop_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chop |-> (chop_len < REFRESH_CYC));

   p_chop_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (chop && gate_req && chop_len == REFRESH_CYC - 1) |=> !chop);

   p_fault_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chop |-> fault);

   p_drop_ends_chop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chop && !gate_req) |=> !chop);

   p_off_high_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_req && drain_high) |=> !fault);

endmodule

bind drain_fault_monitor dfm_checker #(
   .REFRESH_CYC (REFRESH_CYC)
) u_dfm_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .gate_req   (gate_req),
   .drain_high (drain_high),
   .gate_drive (gate_drive),
   .chop       (chop),
   .fault      (fault)
);

// File: tb/test_drain_fault_monitor.sv
module test_drain_fault_monitor;

   localparam int SENSE = 5;
   localparam int OPEN  = 4;
   localparam int REFR  = 30;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic dh = 1'b1;
   logic gate_drive, chop, fault;

   int    checks = 0;
   int    errors = 0;
   string tag = "R1";
   bit    done = 1'b0;

   // reference model state
   int m_ref = 0;    // chopped cycles still to come
   int m_run = 0;    // length of the current sample run
   int m_cls = 0;    // 0 none,1 off-low,2 off-high,3 on-low,4 on-high,5 refresh
   bit m_retry = 1'b0;
   bit m_fault = 1'b0;

   always #5 clk = ~clk;

   drain_fault_monitor #(
      .SENSE_CYC   (SENSE),
      .OPEN_CYC    (OPEN),
      .REFRESH_CYC (REFR)
   ) i_drain_fault_monitor (
      .clk        (clk),
      .rst_n      (rst_n),
      .gate_req   (req),
      .drain_high (dh),
      .gate_drive (gate_drive),
      .chop       (chop),
      .fault      (fault)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ref = 0; m_run = 0; m_cls = 0; m_retry = 1'b0; m_fault = 1'b0;
      end else if (!req) begin
         m_ref = 0;
         m_retry = 1'b0;
         if (dh) begin
            m_cls = 2; m_run = 0; m_fault = 1'b0;
         end else begin
            m_run = (m_cls == 1) ? m_run + 1 : 1;
            m_cls = 1;
            m_fault = (m_run >= OPEN);
         end
      end else if (m_ref > 0) begin
         m_ref = m_ref - 1;
         m_cls = 5;
      end else if (dh) begin
         m_run = (m_cls == 4) ? m_run + 1 : 1;
         m_cls = 4;
         if (m_run >= SENSE) begin
            m_ref = REFR; m_fault = 1'b1; m_retry = 1'b1; m_cls = 5; m_run = 0;
         end else if (!m_retry) begin
            m_fault = 1'b0;
         end
      end else begin
         m_run = (m_cls == 3) ? m_run + 1 : 1;
         m_cls = 3;
         if (!m_retry) m_fault = 1'b0;
         else if (m_run >= SENSE) begin
            m_retry = 1'b0; m_fault = 1'b0;
         end
      end
   end

   task automatic chk(string t, string nm, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, nm, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(tag, "gate_drive", gate_drive, req && (m_ref == 0));
         chk(tag, "chop", chop, m_ref > 0);
         chk(tag, "fault", fault, m_fault);
      end
   end

   task automatic apply(bit r, bit d, int n);
      @(negedge clk);
      #1;
      req = r;
      dh = d;
      repeat (n) @(posedge clk);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_up();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "fault", fault, 1'b0);
      chk("R1", "chop", chop, 1'b0);
      chk("R1", "gate_drive", gate_drive, 1'b0);
      #1 rst_n = 1'b1;
      tag = "R1";
      apply(0, 1, 2);

      // R2: gate follows request
      tag = "R2";
      apply(1, 0, 8);
      apply(0, 1, 4);
      apply(1, 0, 3);

      // R10: runs one edge short of the limit, on and off
      tag = "R10";
      apply(1, 1, SENSE - 1);
      apply(1, 0, 3);
      apply(1, 1, SENSE - 1);
      apply(0, 1, 2);
      apply(0, 0, OPEN - 1);
      apply(0, 1, 2);

      // R3: short qualification
      tag = "R3";
      apply(1, 0, 2);
      apply(1, 1, SENSE + 2);

      // R11: drain toggles during refresh
      tag = "R11";
      for (int i = 0; i < 16; i++) apply(1, i[0], 1);

      // R4: refresh length and re-enable
      tag = "R4";
      apply(1, 1, REFR + SENSE);

      // R6: repeated retry into a persistent short
      tag = "R6";
      apply(1, 1, 2 * (REFR + SENSE) + 3);

      // R5: fault held through refresh, cleared by a clean window
      tag = "R5";
      apply(1, 0, REFR + SENSE + 6);

      // R7: request dropped during refresh
      tag = "R7";
      apply(1, 1, SENSE + 3);
      apply(0, 1, 3);
      apply(1, 1, SENSE + 2);
      apply(0, 0, OPEN + 2);

      // R8: open load when off, no open check when on
      tag = "R8";
      apply(0, 1, 2);
      apply(0, 0, OPEN + 3);
      apply(1, 0, 4);

      // R9: fault clears when drain returns high with gate off
      tag = "R9";
      apply(0, 0, OPEN + 1);
      apply(0, 1, 3);
      apply(0, 1, 1);

      finish_up();
   end

endmodule